// File: doc/BRIEF.md
# Byte/Word Arithmetic-Logic Unit with Status Flags

This block is the arithmetic and logic stage of a small integer datapath. Each cycle it takes an operation code, a byte/word size select and two operands. It produces a result combinationally, together with a result-write enable. It also produces a candidate set of six status flags: carry, parity, auxiliary carry, zero, sign and overflow. When the flag strobe is high, the flags chosen by the operation's update rule are loaded into a flag register on the next rising clock edge. The other flags keep their old values.

The carry used by add-with-carry, subtract-with-borrow and the rotates through carry comes from this internal flag register. A sequence of operations therefore chains naturally. In byte mode only the low eight bits of the operands take part. Carry, sign, zero and overflow are taken at bit 7, and the upper result bits are zero. Shifts and rotates move the operand by exactly one bit position.

Top module: `stat_alu`

## Requirements
- R1: Opcodes ADD=0, ADC=1, SUB=2, SBB=3 and NEG=7 (result 0 minus A) produce the sum or difference at the selected size, and carry is the carry or borrow out of the top bit of that size. ADC adds the stored carry and SBB subtracts it.
- R2: For every arithmetic opcode (0 to 7), auxiliary carry is the carry or borrow out of bit 3.
- R3: For every arithmetic opcode, overflow is set exactly when the result does not fit as a signed value of the selected size.
- R4: Wherever they are updated, zero is set for an all-zero result, sign copies the top bit at the selected size, and parity is set when the low 8 result bits hold an even number of ones, also for words.
- R5: CMP=4 updates the flags as SUB does and TEST=12 as AND does. Both hold res_we_o low; every other defined opcode holds it high.
- R6: INC=5 and DEC=6 add or subtract one and update every arithmetic flag except carry, which is kept.
- R7: AND=8, OR=9, XOR=10 and TEST clear carry, overflow and auxiliary carry. NOT=11 inverts A and changes no flag.
- R8: SHL=13 moves A left by one with zero fill; carry gets the old top bit and overflow is the new top bit XOR carry. SHR=14 fills with zero and SAR=15 repeats the sign bit; both put the old bit 0 in carry. Overflow is the old top bit for SHR and zero for SAR. All three clear auxiliary carry.
- R9: ROL=16 and ROR=17 wrap the end bit around and copy it into carry. RCL=18 and RCR=19 rotate through carry, treating it as one more bit. Overflow is the new top bit XOR carry for left rotates and the XOR of the two top result bits for right rotates. Rotates change only carry and overflow.
- R10: flags_o is {OF,SF,ZF,AF,PF,CF} on bits 5 down to 0. It resets to zero, loads on a clock edge with flag_we_i high, and holds while flag_we_i is low.
- R11: With word_i low, res_o bits 15..8 are zero and all flags are taken at byte size.
- R12: Opcodes 20 to 31 give a zero result, hold res_we_o low and change no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 5 | Operation code |
| word_i | input | 1 | 1 = 16-bit operands, 0 = 8-bit operands |
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand |
| flag_we_i | input | 1 | Load updated flags on the next edge |
| res_o | output | 16 | Result |
| res_we_o | output | 1 | Result should be written back |
| flags_o | output | 6 | Flag register {OF,SF,ZF,AF,PF,CF} |

## Verification
The sweep aims at the boundaries where flags change: 0x7F/0x80 and 0x7FFF/0x8000 for signed overflow, 0x0F/0x10 for the nibble carry, and 0xFF/0x100 where a byte carry must not leak into bit 8. A design that took carry at the wrong bit would report the word carry for byte operations. One that measured parity over all 16 bits would flip PF for words with an odd upper byte. Each operation runs with the stored carry both clear and set. This shows whether ADC, SBB, RCL and RCR really use the carry and whether INC, DEC and the rotates keep the flags they should keep. Running the same operands with the flag strobe low shows whether the register leaks updates.

// File: rtl/stat_alu_pkg.sv
package stat_alu_pkg;

  localparam int BYTE_W = 8;
  localparam int FLAG_W = 6;

  typedef enum logic [4:0] {
    OP_ADD  = 5'd0,
    OP_ADC  = 5'd1,
    OP_SUB  = 5'd2,
    OP_SBB  = 5'd3,
    OP_CMP  = 5'd4,
    OP_INC  = 5'd5,
    OP_DEC  = 5'd6,
    OP_NEG  = 5'd7,
    OP_AND  = 5'd8,
    OP_OR   = 5'd9,
    OP_XOR  = 5'd10,
    OP_NOT  = 5'd11,
    OP_TEST = 5'd12,
    OP_SHL  = 5'd13,
    OP_SHR  = 5'd14,
    OP_SAR  = 5'd15,
    OP_ROL  = 5'd16,
    OP_ROR  = 5'd17,
    OP_RCL  = 5'd18,
    OP_RCR  = 5'd19
  } alu_op_e;

  // Bit order matches flags_o: cf is bit 0, of is bit 5.
  typedef struct packed {
    logic of;
    logic sf;
    logic zf;
    logic af;
    logic pf;
    logic cf;
  } alu_flags_t;

  function automatic logic even_ones8(input logic [BYTE_W-1:0] v);
    return ~(^v);
  endfunction

endpackage

// File: rtl/stat_alu_arith.sv
module stat_alu_arith
  import stat_alu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  alu_op_e      op,
  input  logic         word,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] res,
  output logic         cf,
  output logic         af,
  output logic         of
);

  localparam int MSB  = W - 1;
  localparam int BMSB = BYTE_W - 1;

  function automatic logic [W-1:0] fit(input logic [W-1:0] v, input logic wd);
    return wd ? v : {{(W-BYTE_W){1'b0}}, v[BMSB:0]};
  endfunction

  function automatic logic top_bit(input logic [W-1:0] v, input logic wd);
    return wd ? v[MSB] : v[BMSB];
  endfunction

  logic         is_sub;
  logic         c_in;
  logic [W-1:0] xa;
  logic [W-1:0] yb;
  logic [W:0]   raw;
  logic [4:0]   nib;
  logic         sx, sy, sr;

  always_comb begin
    xa     = fit(a, word);
    yb     = fit(b, word);
    is_sub = 1'b0;
    c_in   = 1'b0;
    case (op)
      OP_ADC:         c_in = cin;
      OP_SUB, OP_CMP: is_sub = 1'b1;
      OP_SBB: begin
        is_sub = 1'b1;
        c_in   = cin;
      end
      OP_INC: yb = {{(W-1){1'b0}}, 1'b1};
      OP_DEC: begin
        yb     = {{(W-1){1'b0}}, 1'b1};
        is_sub = 1'b1;
      end
      OP_NEG: begin
        xa     = '0;
        yb     = fit(a, word);
        is_sub = 1'b1;
      end
      default: ;
    endcase
  end

  always_comb begin
    if (is_sub) begin
      raw = {1'b0, xa} - {1'b0, yb} - {{W{1'b0}}, c_in};
      nib = {1'b0, xa[3:0]} - {1'b0, yb[3:0]} - {4'b0, c_in};
    end else begin
      raw = {1'b0, xa} + {1'b0, yb} + {{W{1'b0}}, c_in};
      nib = {1'b0, xa[3:0]} + {1'b0, yb[3:0]} + {4'b0, c_in};
    end
  end

  assign res = fit(raw[W-1:0], word);
  assign cf  = word ? raw[W] : raw[BYTE_W];
  assign af  = nib[4];
  assign sx  = top_bit(xa, word);
  assign sy  = top_bit(yb, word);
  assign sr  = top_bit(res, word);
  assign of  = is_sub ? ((sx ^ sy) & (sr ^ sx)) : (~(sx ^ sy) & (sr ^ sx));

  AST_NEG_ZERO_NO_BORROW: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_NEG && fit(a, word) == '0) |-> (!cf && res == '0)); // R1
  AST_ADD_MIXED_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_ADD && top_bit(a, word) != top_bit(b, word)) |-> !of); // R3

endmodule

// File: rtl/stat_alu_logic.sv
module stat_alu_logic
  import stat_alu_pkg::*;
#(
  parameter int W = 16
) (
  input  alu_op_e      op,
  input  logic         word,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] res
);

  logic [W-1:0] raw;

  always_comb begin
    case (op)
      OP_AND, OP_TEST: raw = a & b;
      OP_OR:           raw = a | b;
      OP_XOR:          raw = a ^ b;
      OP_NOT:          raw = ~a;
      default:         raw = '0;
    endcase
  end

  assign res = word ? raw : {{(W-BYTE_W){1'b0}}, raw[BYTE_W-1:0]};

endmodule

// File: rtl/stat_alu_shift.sv
module stat_alu_shift
  import stat_alu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  alu_op_e      op,
  input  logic         word,
  input  logic [W-1:0] a,
  input  logic         cin,
  output logic [W-1:0] res,
  output logic         cf,
  output logic         of
);

  localparam int MSB  = W - 1;
  localparam int BMSB = BYTE_W - 1;

  function automatic logic [W-1:0] fit(input logic [W-1:0] v, input logic wd);
    return wd ? v : {{(W-BYTE_W){1'b0}}, v[BMSB:0]};
  endfunction

  function automatic logic top_bit(input logic [W-1:0] v, input logic wd);
    return wd ? v[MSB] : v[BMSB];
  endfunction

  logic [W-1:0] x;
  logic [W-1:0] top_mask;
  logic [W-1:0] raw;
  logic         xt;
  logic         rt;
  logic         rn;

  assign x        = fit(a, word);
  assign xt       = top_bit(x, word);
  assign top_mask = word ? (W'(1) << MSB) : (W'(1) << BMSB);

  always_comb begin
    raw = '0;
    cf  = 1'b0;
    case (op)
      OP_SHL: begin raw = x << 1;                               cf = xt;   end
      OP_SHR: begin raw = x >> 1;                               cf = x[0]; end
      OP_SAR: begin raw = (x >> 1) | (xt ? top_mask : '0);      cf = x[0]; end
      OP_ROL: begin raw = (x << 1) | {{(W-1){1'b0}}, xt};       cf = xt;   end
      OP_ROR: begin raw = (x >> 1) | (x[0] ? top_mask : '0);    cf = x[0]; end
      OP_RCL: begin raw = (x << 1) | {{(W-1){1'b0}}, cin};      cf = xt;   end
      OP_RCR: begin raw = (x >> 1) | (cin ? top_mask : '0);     cf = x[0]; end
      default: ;
    endcase
  end

  assign res = fit(raw, word);
  assign rt  = top_bit(res, word);
  assign rn  = word ? res[MSB-1] : res[BMSB-1];

  always_comb begin
    case (op)
      OP_SHL, OP_ROL, OP_RCL: of = rt ^ cf;
      OP_SHR:                 of = xt;
      OP_ROR, OP_RCR:         of = rt ^ rn;
      default:                of = 1'b0;
    endcase
  end

  AST_SAR_SIGN_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_SAR) |-> (top_bit(res, word) == top_bit(a, word))); // R8
  AST_RCL_CARRY_ENTERS: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_RCL) |-> (res[0] == cin)); // R9

endmodule

// File: rtl/stat_alu_flag_reg.sv
module stat_alu_flag_reg
  import stat_alu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [FLAG_W-1:0] mask,
  input  logic [FLAG_W-1:0] nxt,
  output logic [FLAG_W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (we) begin
      q <= (q & ~mask) | (nxt & mask);
    end
  end

  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(q)); // R10
  AST_MASKED_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> ((q & ~$past(mask)) == ($past(q) & ~$past(mask)))); // R12

endmodule

// File: rtl/stat_alu.sv
module stat_alu
  import stat_alu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [4:0]        op_i,
  input  logic              word_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              flag_we_i,
  output logic [DATA_W-1:0] res_o,
  output logic              res_we_o,
  output logic [FLAG_W-1:0] flags_o
);

  localparam int MSB = DATA_W - 1;
  localparam logic [FLAG_W-1:0] UPD_ALL   = 6'h3F;
  localparam logic [FLAG_W-1:0] UPD_NO_CF = 6'h3E;
  localparam logic [FLAG_W-1:0] UPD_CF_OF = 6'h21;

  alu_op_e           op;
  logic              arith_sel, logic_sel, shift_sel, wr;
  logic [FLAG_W-1:0] upd_mask;
  logic [DATA_W-1:0] ar_res, lg_res, sh_res;
  logic              ar_cf, ar_af, ar_of;
  logic              sh_cf, sh_of;
  logic              cur_cf;
  alu_flags_t        nxt;

  assign op     = alu_op_e'(op_i);
  assign cur_cf = flags_o[0];

  always_comb begin
    arith_sel = 1'b0;
    logic_sel = 1'b0;
    shift_sel = 1'b0;
    wr        = 1'b0;
    upd_mask  = '0;
    case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBB, OP_NEG: begin
        arith_sel = 1'b1; wr = 1'b1; upd_mask = UPD_ALL;
      end
      OP_CMP: begin
        arith_sel = 1'b1; upd_mask = UPD_ALL;
      end
      OP_INC, OP_DEC: begin
        arith_sel = 1'b1; wr = 1'b1; upd_mask = UPD_NO_CF;
      end
      OP_AND, OP_OR, OP_XOR: begin
        logic_sel = 1'b1; wr = 1'b1; upd_mask = UPD_ALL;
      end
      OP_TEST: begin
        logic_sel = 1'b1; upd_mask = UPD_ALL;
      end
      OP_NOT: begin
        logic_sel = 1'b1; wr = 1'b1;
      end
      OP_SHL, OP_SHR, OP_SAR: begin
        shift_sel = 1'b1; wr = 1'b1; upd_mask = UPD_ALL;
      end
      OP_ROL, OP_ROR, OP_RCL, OP_RCR: begin
        shift_sel = 1'b1; wr = 1'b1; upd_mask = UPD_CF_OF;
      end
      default: ;
    endcase
  end

  stat_alu_arith #(.W(DATA_W)) u_arith (
    .clk  (clk),
    .rst_n(rst_n),
    .op   (op),
    .word (word_i),
    .a    (a_i),
    .b    (b_i),
    .cin  (cur_cf),
    .res  (ar_res),
    .cf   (ar_cf),
    .af   (ar_af),
    .of   (ar_of)
  );

  stat_alu_logic #(.W(DATA_W)) u_logic (
    .op  (op),
    .word(word_i),
    .a   (a_i),
    .b   (b_i),
    .res (lg_res)
  );

  stat_alu_shift #(.W(DATA_W)) u_shift (
    .clk  (clk),
    .rst_n(rst_n),
    .op   (op),
    .word (word_i),
    .a    (a_i),
    .cin  (cur_cf),
    .res  (sh_res),
    .cf   (sh_cf),
    .of   (sh_of)
  );

  always_comb begin
    if (arith_sel)      res_o = ar_res;
    else if (logic_sel) res_o = lg_res;
    else if (shift_sel) res_o = sh_res;
    else                res_o = '0;
  end

  assign res_we_o = wr;

  always_comb begin
    nxt.zf = (res_o == '0);
    nxt.sf = word_i ? res_o[MSB] : res_o[BYTE_W-1];
    nxt.pf = even_ones8(res_o[BYTE_W-1:0]);
    nxt.cf = arith_sel ? ar_cf : (shift_sel ? sh_cf : 1'b0);
    nxt.of = arith_sel ? ar_of : (shift_sel ? sh_of : 1'b0);
    nxt.af = arith_sel ? ar_af : 1'b0;
  end

  stat_alu_flag_reg u_flags (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (flag_we_i),
    .mask (upd_mask),
    .nxt  (nxt),
    .q    (flags_o)
  );

  AST_COMPARE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 5'd4 || op_i == 5'd12) |-> !res_we_o); // R5
  AST_INCDEC_KEEP_CF: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we_i && (op_i == 5'd5 || op_i == 5'd6)) |=> (flags_o[0] == $past(flags_o[0]))); // R6
  AST_LOGIC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we_i && op_i >= 5'd8 && op_i <= 5'd12 && op_i != 5'd11)
      |=> (!flags_o[0] && !flags_o[2] && !flags_o[5])); // R7
  AST_ROTATE_ONLY_CF_OF: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we_i && op_i >= 5'd16 && op_i <= 5'd19) |=> (flags_o[4:1] == $past(flags_o[4:1]))); // R9
  AST_BYTE_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !word_i |-> (res_o[MSB:BYTE_W] == '0)); // R11

endmodule

// File: tb/stat_alu_bench.sv
module stat_alu_bench;

  logic        clk;
  logic        rst_n;
  logic [4:0]  op_i;
  logic        word_i;
  logic [15:0] a_i, b_i;
  logic        flag_we_i;
  logic [15:0] res_o;
  logic        res_we_o;
  logic [5:0]  flags_o;

  int total = 0;
  int bad   = 0;
  logic [5:0] exp_fl;
  bit done = 0;

  stat_alu u_stat_alu (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_i     (op_i),
    .word_i   (word_i),
    .a_i      (a_i),
    .b_i      (b_i),
    .flag_we_i(flag_we_i),
    .res_o    (res_o),
    .res_we_o (res_we_o),
    .flags_o  (flags_o)
  );

  initial clk = 0;
  always #10 clk = ~clk;

  logic [15:0] bvals [16] = '{16'h00, 16'h01, 16'h02, 16'h07, 16'h08, 16'h0F, 16'h10, 16'h3C,
                              16'h55, 16'h7E, 16'h7F, 16'h80, 16'h81, 16'hAA, 16'hFE, 16'hFF};
  logic [15:0] wvals [16] = '{16'h0000, 16'h0001, 16'h000F, 16'h0010, 16'h007F, 16'h0080, 16'h00FF, 16'h0100,
                              16'h0FFF, 16'h5555, 16'h7FFF, 16'h8000, 16'h8001, 16'hAAAA, 16'hFFFE, 16'hFFFF};

  function automatic string req_tag(int op);
    if (op <= 3 || op == 7) return "R1";
    if (op == 4)  return "R5";
    if (op <= 6)  return "R6";
    if (op <= 12) return "R7";
    if (op <= 15) return "R8";
    if (op <= 19) return "R9";
    return "R12";
  endfunction

  // Returns {write, result[15:0], flags[5:0]} worked out from the requirements.
  function automatic logic [22:0] ref_model(int op, bit wd, int a, int b, logic [5:0] fl);
    int n   = wd ? 16 : 8;
    int msk = (1 << n) - 1;
    int top = 1 << (n - 1);
    int x   = a & msk;
    int y   = b & msk;
    int c   = int'(fl[0]);
    int r   = 0;
    int t   = 0;
    int p   = 0;
    int q   = 0;
    int ones = 0;
    bit cf = fl[0], pf = fl[1], af = fl[2], zf = fl[3], sf = fl[4], of = fl[5];
    bit wr = 1, szp = 1;
    case (op)
      0, 1: begin
        t  = (op == 1) ? c : 0;
        r  = (x + y + t) & msk;
        cf = (x + y + t) > msk;
        af = ((x & 15) + (y & 15) + t) > 15;
        of = ((x ^ r) & (y ^ r) & top) != 0;
      end
      2, 3, 4, 7: begin
        p = x; q = y;
        if (op == 7) begin p = 0; q = x; end
        t  = (op == 3) ? c : 0;
        r  = (p - q - t) & msk;
        cf = (p - q - t) < 0;
        af = ((p & 15) - (q & 15) - t) < 0;
        of = ((p ^ q) & (p ^ r) & top) != 0;
        if (op == 4) wr = 0;
      end
      5: begin
        r  = (x + 1) & msk;
        af = ((x & 15) + 1) > 15;
        of = ((x ^ r) & (1 ^ r) & top) != 0;
      end
      6: begin
        r  = (x - 1) & msk;
        af = (x & 15) == 0;
        of = ((x ^ 1) & (x ^ r) & top) != 0;
      end
      8, 9, 10, 12: begin
        if (op == 9)       r = x | y;
        else if (op == 10) r = x ^ y;
        else               r = x & y;
        cf = 0; of = 0; af = 0;
        if (op == 12) wr = 0;
      end
      11: begin r = ~x & msk; szp = 0; end
      13: begin r = (x << 1) & msk; cf = (x & top) != 0; of = ((r & top) != 0) ^ cf; af = 0; end
      14: begin r = x >> 1; cf = (x & 1) != 0; of = (x & top) != 0; af = 0; end
      15: begin r = (x >> 1) | (x & top); cf = (x & 1) != 0; of = 0; af = 0; end
      16: begin
        r = ((x << 1) & msk) | (((x & top) != 0) ? 1 : 0);
        cf = (r & 1) != 0; of = ((r & top) != 0) ^ cf; szp = 0;
      end
      17: begin
        r = (x >> 1) | (((x & 1) != 0) ? top : 0);
        cf = (r & top) != 0; of = cf ^ ((r & (top >> 1)) != 0); szp = 0;
      end
      18: begin
        r = ((x << 1) & msk) | c;
        cf = (x & top) != 0; of = ((r & top) != 0) ^ cf; szp = 0;
      end
      19: begin
        r = (x >> 1) | ((c != 0) ? top : 0);
        cf = (x & 1) != 0; of = ((r & top) != 0) ^ ((r & (top >> 1)) != 0); szp = 0;
      end
      default: begin r = 0; wr = 0; szp = 0; end
    endcase
    if (szp) begin
      for (int i = 0; i < 8; i++) ones += (r >> i) & 1;
      pf = (ones % 2) == 0;
      zf = (r == 0);
      sf = (r & top) != 0;
    end
    return {wr, r[15:0], of, sf, zf, af, pf, cf};
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  task automatic step(int op, bit wd, logic [15:0] a, logic [15:0] b, bit we);
    logic [22:0] e;
    @(negedge clk);
    op_i = op[4:0]; word_i = wd; a_i = a; b_i = b; flag_we_i = we;
    #2;
    e = ref_model(op, wd, int'(a), int'(b), exp_fl);
    check(res_o == e[21:6], (!wd && res_o[15:8] != 0) ? "R11" : req_tag(op), "result",
          int'(res_o), int'(e[21:6]));
    check(res_we_o == e[22], (op == 4 || op == 12) ? "R5" : req_tag(op), "res_we",
          int'(res_we_o), int'(e[22]));
    if (we) exp_fl = e[5:0];
    @(posedge clk);
    #3;
    check(flags_o == exp_fl, we ? req_tag(op) : "R10", "flags", int'(flags_o), int'(exp_fl));
    flag_we_i = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; op_i = 0; word_i = 0; a_i = 0; b_i = 0; flag_we_i = 0;
    exp_fl = '0;
    repeat (3) @(posedge clk);
    #3;
    check(flags_o == 6'h00, "R10", "reset flags", int'(flags_o), 0);
    @(negedge clk);
    rst_n = 1;

    // Sweep every opcode (R1..R9, R12), both sizes (R11), both carry states (R2, R3, R4 via flags).
    for (int op = 0; op < 22; op++) begin
      for (int wd = 0; wd < 2; wd++) begin
        for (int ia = 0; ia < 16; ia++) begin
          for (int ib = 0; ib < 16; ib++) begin
            for (int cv = 0; cv < 2; cv++) begin
              step(2, 1'b0, 16'h0000, cv[15:0], 1'b1);
              step(op, wd[0], wd ? wvals[ia] : bvals[ia], wd ? wvals[ib] : bvals[ib], 1'b1);
            end
          end
        end
      end
    end

    // Word operands with a nonzero upper byte fed in byte mode (R11).
    for (int k = 0; k < 16; k++) begin
      step(k, 1'b0, 16'hA500 | bvals[k], 16'h5A00 | bvals[15-k], 1'b1);
    end

    // Flag strobe low: register must hold (R10).
    step(2, 1'b0, 16'h0000, 16'h0001, 1'b1);
    for (int k = 0; k < 20; k++) begin
      step(k, k[0], wvals[k % 16], wvals[(k * 7) % 16], 1'b0);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule